// File: doc/BRIEF.md
# Multi-Mode Sequential Divider

This block divides a dividend by a 16-bit divisor one quotient bit per clock step. One datapath handles five modes. Two take a 32-bit dividend, signed or unsigned. Two take a 16-bit dividend, signed or unsigned, and extend it to 32 bits when loading. The fifth is a signed Q15 fractional divide, in which the dividend is scaled so that the quotient is itself a Q15 number. A controller pulses start with the operands and the mode. Every divide uses the same fixed sequence: one cycle to load, then 18 steps. The last step drives a quotient, a remainder and a flag for overflow or a zero divisor.

The operation can be paused mid-way. While hold is high, every internal register keeps its value and the step counter does not move. A host can therefore suspend the divider, do other work, and resume it later without any loss. Signed modes work on magnitudes with a non-restoring step and correct the signs at the end. Results stay on the outputs until the next divide completes.

Top module: `seqdiv_top`

## Requirements
- R1: Mode code 2 (and the unused codes 5 to 7) divides the 32-bit dividend by the divisor as unsigned numbers; when no overflow is flagged, quot_o is the quotient and rem_o the remainder.
- R2: Mode code 1 divides the 32-bit dividend by the divisor as two's-complement numbers; the quotient is truncated toward zero and the remainder takes the sign of the dividend.
- R3: Mode codes 3 (signed) and 4 (unsigned) use only dividend_i[15:0], sign-extended or zero-extended, and ignore dividend_i[31:16].
- R4: Mode code 0 treats dividend_i[15:0] and the divisor as signed Q15 values; quot_o equals (dividend × 32768) / divisor truncated toward zero, and rem_o is the matching remainder with the dividend's sign.
- R5: ovf_o is set when the divisor is zero or when the true quotient does not fit in 16 bits (signed range -32768..32767, unsigned range 0..65535); otherwise it is clear.
- R6: A start accepted on a clock edge raises busy_o, and 18 further edges without hold finish the divide; done_o is then high for exactly one cycle while busy_o is low.
- R7: Each clock edge with hold_i high during a divide freezes all progress and delays done_o by exactly one cycle, without changing the result.
- R8: A start pulse while busy_o is high is ignored: the running divide finishes on time with its own operands.
- R9: After a synchronous reset, busy_o, done_o, ovf_o, quot_o and rem_o are all zero.
- R10: quot_o, rem_o and ovf_o change only in the cycle in which done_o is high, and otherwise hold the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Launch a divide when idle |
| hold_i | input | 1 | Freeze an ongoing divide |
| mode_i | input | 3 | Mode code (0 frac, 1 s32, 2 u32, 3 s16, 4 u16) |
| dividend_i | input | 32 | Dividend; the 16-bit modes use the low half |
| divisor_i | input | 16 | Divisor |
| quot_o | output | 16 | Quotient of the last completed divide |
| rem_o | output | 16 | Remainder of the last completed divide |
| busy_o | output | 1 | Divide in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ovf_o | output | 1 | Overflow or zero divisor on the last divide |

## Verification
The assertions assume that start_i and hold_i are synchronous and stable across the sampling edge. They also assume that reset is held for at least one edge before any checks, so that the stability properties have a defined previous value. The stimulus changes inputs only on falling edges and holds reset for several cycles. It raises hold only while a divide is running. It also fires stray start pulses only mid-divide, so that the counting and ignore properties see the situations they are written for.

// File: rtl/seqdiv_pkg.sv
// Package: shared mode codes for the sequential divider.
// Assumes a 3-bit mode field; codes above MODE_U16 are treated as unsigned 32/16.
package seqdiv_pkg;

    typedef enum logic [2:0] {
        MODE_FRAC = 3'd0,
        MODE_S32  = 3'd1,
        MODE_U32  = 3'd2,
        MODE_S16  = 3'd3,
        MODE_U16  = 3'd4
    } div_mode_e;

endpackage

// File: rtl/seqdiv_prep.sv
// Operand conditioning: turns the raw dividend and divisor into unsigned
// magnitudes of a 2W-bit numerator and W-bit denominator, plus the signs
// to apply at the end. Purely combinational.
// Assumes two's-complement inputs; |most negative| fits as an unsigned magnitude.
module seqdiv_prep
    import seqdiv_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [2:0]     mode,
    input  logic [2*W-1:0] dividend,
    input  logic [W-1:0]   divisor,
    output logic [2*W-1:0] num_mag,
    output logic [W-1:0]   den_mag,
    output logic           q_neg,
    output logic           r_neg,
    output logic           signed_op
);

    logic [2*W-1:0] num_ext;
    logic           num_sgn;
    logic [W-1:0]   lo_mag;

    // Select the extended numerator, its sign and the signedness per mode.
    always_comb begin
        num_ext   = dividend;
        num_sgn   = 1'b0;
        signed_op = 1'b0;
        lo_mag    = dividend[W-1] ? -dividend[W-1:0] : dividend[W-1:0];
        case (mode)
            MODE_FRAC: begin
                signed_op = 1'b1;
                num_sgn   = dividend[W-1];
                num_ext   = {{W{1'b0}}, lo_mag} << (W-1);
            end
            MODE_S32: begin
                signed_op = 1'b1;
                num_sgn   = dividend[2*W-1];
                num_ext   = dividend;
            end
            MODE_S16: begin
                signed_op = 1'b1;
                num_sgn   = dividend[W-1];
                num_ext   = {{W{dividend[W-1]}}, dividend[W-1:0]};
            end
            MODE_U16: begin
                num_ext   = {{W{1'b0}}, dividend[W-1:0]};
            end
            default: begin
                num_ext   = dividend;
            end
        endcase
    end

    // Take magnitudes and derive the result signs.
    always_comb begin
        logic d_sgn;
        d_sgn   = signed_op & divisor[W-1];
        den_mag = d_sgn ? -divisor : divisor;
        if (mode == MODE_FRAC) begin
            num_mag = num_ext;
        end else begin
            num_mag = num_sgn ? -num_ext : num_ext;
        end
        q_neg = num_sgn ^ d_sgn;
        r_neg = num_sgn;
    end

endmodule

// File: rtl/seqdiv_step.sv
// One non-restoring division step on a signed partial remainder.
// Shifts in the next numerator bit, adds or subtracts the divisor by the
// sign of the current remainder, and yields the quotient bit.
// Assumes |partial| < divisor on entry (guaranteed unless overflow was flagged).
module seqdiv_step #(
    parameter int W = 16
) (
    input  logic [W+2:0] part,
    input  logic         nbit,
    input  logic [W-1:0] den,
    output logic [W+2:0] part_nxt,
    output logic         qbit
);

    logic [W+2:0] shifted;
    logic [W+2:0] den_ext;

    // Compute the next partial remainder and the quotient bit.
    always_comb begin
        shifted  = {part[W+1:0], nbit};
        den_ext  = {3'b000, den};
        part_nxt = part[W+2] ? (shifted + den_ext) : (shifted - den_ext);
        qbit     = ~part_nxt[W+2];
    end

endmodule

// File: rtl/seqdiv_ctrl.sv
// Sequencer: accepts a start when idle, counts STEPS steps, freezes on hold,
// and emits a one-cycle done pulse after the last step.
// Assumes start and hold are synchronous to clk.
module seqdiv_ctrl #(
    parameter int STEPS = 18,
    localparam int CW   = $clog2(STEPS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          hold,
    output logic          busy,
    output logic          done,
    output logic [CW-1:0] cnt,
    output logic          load,
    output logic          adv
);

    localparam logic [CW-1:0] LAST_IDX = CW'(STEPS - 1);

    // Decode launch and advance conditions.
    always_comb begin
        load = start & ~busy;
        adv  = busy & ~hold;
    end

    // Step counter, busy flag and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
        end else begin
            done <= 1'b0;
            if (load) begin
                busy <= 1'b1;
                cnt  <= '0;
            end else if (adv) begin
                if (cnt == LAST_IDX) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    cnt  <= '0;
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end
        end
    end

    AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        busy && hold |=> busy && $stable(cnt)); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && $past(busy)); // R6

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start && !hold && cnt != LAST_IDX |=> busy && cnt == $past(cnt) + CW'(1)); // R8

endmodule

// File: rtl/seqdiv_top.sv
// Multi-mode sequential divider top. A load cycle conditions the operands.
// Step 0 checks for a zero divisor and a quotient that is too large.
// Steps 1..W each produce one quotient bit. Step W+1 corrects the remainder,
// applies the signs and registers the results.
// Assumes the caller leaves mode/operands meaningful only on the start cycle.
module seqdiv_top
    import seqdiv_pkg::*;
#(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic           hold_i,
    input  logic [2:0]     mode_i,
    input  logic [2*W-1:0] dividend_i,
    input  logic [W-1:0]   divisor_i,
    output logic [W-1:0]   quot_o,
    output logic [W-1:0]   rem_o,
    output logic           busy_o,
    output logic           done_o,
    output logic           ovf_o
);

    localparam int STEPS = W + 2;
    localparam int CW    = $clog2(STEPS);
    localparam logic [CW-1:0] CHK_IDX = '0;
    localparam logic [CW-1:0] FIN_IDX = CW'(W + 1);
    localparam logic [W-1:0]  HALF    = {1'b1, {(W-1){1'b0}}};

    logic [2*W-1:0] num_mag;
    logic [W-1:0]   den_mag;
    logic           q_neg, r_neg, signed_op;

    logic [W+2:0]   part_r;
    logic [W-1:0]   num_lo_r;
    logic [W-1:0]   den_r;
    logic [W-1:0]   qmag_r;
    logic           q_neg_r, r_neg_r, signed_r, pre_ovf_r;

    logic [W+2:0]   part_nxt;
    logic           qbit;
    logic [CW-1:0]  cnt;
    logic           load, adv;

    logic [W-1:0]   rmag;
    logic           q_bad;

    seqdiv_prep #(.W(W)) prep_i (
        .mode      (mode_i),
        .dividend  (dividend_i),
        .divisor   (divisor_i),
        .num_mag   (num_mag),
        .den_mag   (den_mag),
        .q_neg     (q_neg),
        .r_neg     (r_neg),
        .signed_op (signed_op)
    );

    seqdiv_step #(.W(W)) step_i (
        .part     (part_r),
        .nbit     (num_lo_r[W-1]),
        .den      (den_r),
        .part_nxt (part_nxt),
        .qbit     (qbit)
    );

    seqdiv_ctrl #(.STEPS(STEPS)) ctrl_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start_i),
        .hold  (hold_i),
        .busy  (busy_o),
        .done  (done_o),
        .cnt   (cnt),
        .load  (load),
        .adv   (adv)
    );

    // Final remainder correction and signed range check.
    always_comb begin
        rmag  = part_r[W-1:0] + (part_r[W+2] ? den_r : '0);
        q_bad = q_neg_r ? (qmag_r > HALF) : qmag_r[W-1];
    end

    // Datapath registers: load, pre-check, iterate, finalize.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            part_r    <= '0;
            num_lo_r  <= '0;
            den_r     <= '0;
            qmag_r    <= '0;
            q_neg_r   <= 1'b0;
            r_neg_r   <= 1'b0;
            signed_r  <= 1'b0;
            pre_ovf_r <= 1'b0;
            quot_o    <= '0;
            rem_o     <= '0;
            ovf_o     <= 1'b0;
        end else if (load) begin
            part_r    <= {3'b000, num_mag[2*W-1:W]};
            num_lo_r  <= num_mag[W-1:0];
            den_r     <= den_mag;
            qmag_r    <= '0;
            q_neg_r   <= q_neg;
            r_neg_r   <= r_neg;
            signed_r  <= signed_op;
            pre_ovf_r <= 1'b0;
        end else if (adv) begin
            if (cnt == CHK_IDX) begin
                pre_ovf_r <= (den_r == '0) || (part_r[W-1:0] >= den_r);
            end else if (cnt == FIN_IDX) begin
                quot_o <= q_neg_r ? -qmag_r : qmag_r;
                rem_o  <= r_neg_r ? -rmag : rmag;
                ovf_o  <= pre_ovf_r | (signed_r & q_bad);
            end else begin
                part_r   <= part_nxt;
                qmag_r   <= {qmag_r[W-2:0], qbit};
                num_lo_r <= {num_lo_r[W-2:0], 1'b0};
            end
        end
    end

    AST_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        adv && cnt == FIN_IDX && den_r == '0 |=> ovf_o); // R5

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(quot_o) && $stable(rem_o) && $stable(ovf_o)); // R10

endmodule

// File: tb/seqdiv_top_tb_top.sv
module seqdiv_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        hold = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic [31:0] dividend = '0;
    logic [15:0] divisor = '0;
    logic [15:0] quot, rem;
    logic        busy, done, ovf;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    seqdiv_top #(.W(16)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .hold_i     (hold),
        .mode_i     (mode),
        .dividend_i (dividend),
        .divisor_i  (divisor),
        .quot_o     (quot),
        .rem_o      (rem),
        .busy_o     (busy),
        .done_o     (done),
        .ovf_o      (ovf)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Arithmetic reference for every mode.
    function automatic void model(input logic [2:0] m, input logic [31:0] dvd,
                                  input logic [15:0] dsr, output bit e_ovf,
                                  output logic [15:0] e_q, output logic [15:0] e_r);
        longint n, d, q, r;
        bit sgn;
        sgn = 1'b1;
        case (m)
            3'd0: begin n = longint'($signed(dvd[15:0])) * 32768; end
            3'd1: begin n = longint'($signed(dvd)); end
            3'd3: begin n = longint'($signed(dvd[15:0])); end
            3'd4: begin n = longint'({48'd0, dvd[15:0]}); sgn = 1'b0; end
            default: begin n = longint'({32'd0, dvd}); sgn = 1'b0; end
        endcase
        d = sgn ? longint'($signed(dsr)) : longint'({48'd0, dsr});
        e_q = '0;
        e_r = '0;
        if (d == 0) begin
            e_ovf = 1'b1;
        end else begin
            q = n / d;
            r = n % d;
            e_ovf = sgn ? (q > 32767 || q < -32768) : (q > 65535);
            e_q = q[15:0];
            e_r = r[15:0];
        end
    endfunction

    function automatic string mode_req(input logic [2:0] m);
        case (m)
            3'd0: return "R4";
            3'd1: return "R2";
            3'd3, 3'd4: return "R3";
            default: return "R1";
        endcase
    endfunction

    // One divide with optional holds and a stray start pulse mid-run.
    task automatic run(input logic [2:0] m, input logic [31:0] dvd,
                       input logic [15:0] dsr, input bit use_hold, input bit poke);
        int cyc;
        int holds;
        bit e_ovf;
        logic [15:0] e_q, e_r;
        @(negedge clk);
        mode = m; dividend = dvd; divisor = dsr; start = 1'b1;
        @(negedge clk);
        start = 1'b0; dividend = ~dvd; divisor = ~dsr; mode = 3'd1;
        cyc = 0;
        holds = 0;
        while (!done && cyc < 60) begin
            hold  = use_hold && (cyc == 2 || cyc == 3 || cyc == 9);
            start = poke && (cyc == 5);
            if (hold) holds++;
            @(negedge clk);
            cyc++;
        end
        hold = 1'b0;
        start = 1'b0;
        if (use_hold) chk("R7", "cycles to done with hold", cyc, 18 + holds);
        else if (poke) chk("R8", "cycles to done with stray start", cyc, 18);
        else chk("R6", "cycles to done", cyc, 18);
        chk("R6", "busy low at done", {31'd0, busy}, 32'd0);
        model(m, dvd, dsr, e_ovf, e_q, e_r);
        chk("R5", "overflow flag", {31'd0, ovf}, {31'd0, e_ovf});
        if (!e_ovf) begin
            chk(mode_req(m), "quotient", {16'd0, quot}, {16'd0, e_q});
            chk(mode_req(m), "remainder", {16'd0, rem}, {16'd0, e_r});
        end
    endtask

    logic [31:0] dvd_set [10] = '{32'd0, 32'd1, 32'd7, 32'h0000_7FFF, 32'h0000_8000,
                                  32'h1234_ABCD, 32'hFFFF_FFFF, 32'h8000_0000,
                                  32'h0001_2345, 32'hFFF0_0001};
    logic [15:0] dsr_set [10] = '{16'h0000, 16'h0001, 16'h0002, 16'h0003, 16'h7FFF,
                                  16'h8000, 16'hFFFF, 16'h00FF, 16'hFF01, 16'h1234};

    initial begin
        logic [15:0] q_keep, r_keep;
        repeat (3) @(negedge clk);
        chk("R9", "busy after reset", {31'd0, busy}, 32'd0);
        chk("R9", "done after reset", {31'd0, done}, 32'd0);
        chk("R9", "ovf after reset", {31'd0, ovf}, 32'd0);
        chk("R9", "quotient after reset", {16'd0, quot}, 32'd0);
        chk("R9", "remainder after reset", {16'd0, rem}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep of corner operands across all five modes.
        for (int m = 0; m < 5; m++)
            for (int i = 0; i < 10; i++)
                for (int j = 0; j < 10; j++)
                    run(3'(m), dvd_set[i], dsr_set[j], ((i + j) % 5) == 0, ((i + j) % 7) == 3);

        // Dense small-value sweep for the signed 16-bit and fractional modes.
        for (int a = -8; a < 8; a++)
            for (int b = -4; b <= 4; b++) begin
                run(3'd3, {16'hA5A5, 16'(a)}, 16'(b), 1'b0, 1'b0);
                run(3'd0, {16'h5A5A, 16'(a)}, 16'(b), 1'b0, 1'b0);
            end

        // Reserved mode code acts as unsigned 32/16 (R1).
        run(3'd6, 32'h00FF_FFFF, 16'h0100, 1'b0, 1'b0);
        run(3'd2, 32'hFFFE_0001, 16'hFFFF, 1'b1, 1'b0);

        // Single-cycle done and held outputs (R6, R10).
        run(3'd2, 32'd1000, 16'd7, 1'b0, 1'b0);
        q_keep = quot;
        r_keep = rem;
        @(negedge clk);
        chk("R6", "done drops after one cycle", {31'd0, done}, 32'd0);
        mode = 3'd1; dividend = 32'hDEAD_BEEF; divisor = 16'd3;
        repeat (4) @(negedge clk);
        chk("R10", "quotient held", {16'd0, quot}, {16'd0, q_keep});
        chk("R10", "remainder held", {16'd0, rem}, {16'd0, r_keep});

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule